// File: doc/BRIEF.md
# JK-entry parallel-load shift register

This block is a short register chain whose first stage is fed by a J input and an active-low K input. It is not fed by a plain serial data bit. A single mode input selects between two behaviours on each rising clock edge.

- **Load mode:** every stage captures its own parallel data bit.
- **Shift mode:** each stage passes its content one place toward the last stage. At the same time, the first stage holds, sets, clears or toggles according to the J/K pair.

An active-low clear empties the chain immediately, without waiting for a clock edge. Besides the stage values, the block drives the complement of the last stage on a separate output. Typical uses are a serial-to-parallel converter, a ring or Johnson-style counter made by feeding the last stage back to J/K, or a loadable pattern source.

Stage 0 (`q[0]`) is the first stage and `q[STAGES-1]` is the last stage. The default length is four stages.

Top module: `jksr_shift_reg`

## Requirements
- R1: With `shift_ld` = 0 at a rising `clk` edge, `q[i]` takes `par_d[i]` for every stage i. Bit 0 is the first stage.
- R2: In load mode the values of `j` and `k_n` have no effect on the loaded result.
- R3: With `shift_ld` = 1 at a rising edge, `q[i]` takes the previous `q[i-1]` for every i from 1 to STAGES-1.
- R4: In shift mode with `j`=0 and `k_n`=1, `q[0]` keeps its previous value.
- R5: In shift mode with `j`=0 and `k_n`=0, `q[0]` becomes 0.
- R6: In shift mode with `j`=1 and `k_n`=1, `q[0]` becomes 1.
- R7: In shift mode with `j`=1 and `k_n`=0, `q[0]` becomes the inverse of its previous value.
- R8: While `clr_n` is 0, all stages are 0. They reach 0 without any clock edge, and no edge, load or shift changes them.
- R9: `q_last_n` always equals the inverse of `q[STAGES-1]`.
- R10: With `clr_n` high and no rising edge, the stages keep their values however `par_d`, `j`, `k_n` or `shift_ld` change.
- R11: The first rising edge after `clr_n` returns high performs a normal load or shift on the cleared contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_ld | input | 1 | Mode select: 0 = parallel load, 1 = shift |
| j | input | 1 | First-stage J input |
| k_n | input | 1 | First-stage K input, active low |
| par_d | input | STAGES | Parallel data, bit 0 to the first stage |
| q | output | STAGES | Stage values, bit 0 is the first stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The clear and a clocked load or shift can fall in the same clock period. The bench provokes this by pulling `clr_n` low a few nanoseconds after a falling edge while load or shift inputs are set up for the next rising edge. In some cases the clear is released before that edge and in others it is held across it. The bench checks that the chain reads zero immediately after the clear falls. Where the clear is held, it checks that the edge leaves the chain at zero. Where the clear is released first, it checks that the edge performs exactly the load or shift a reference model predicts from an all-zero state.

// File: rtl/jksr_pkg.sv
package jksr_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        HEAD_CLEAR  = 2'b00,
        HEAD_HOLD   = 2'b01,
        HEAD_TOGGLE = 2'b10,
        HEAD_SET    = 2'b11
    } head_act_e;

    // J and active-low K map directly onto the action code {j, k_n}.
    function automatic head_act_e decode_head(input logic j, input logic k_n);
        return head_act_e'({j, k_n});
    endfunction

    function automatic logic head_next(input head_act_e act, input logic cur);
        logic nxt;
        unique case (act)
            HEAD_CLEAR:  nxt = 1'b0;
            HEAD_HOLD:   nxt = cur;
            HEAD_TOGGLE: nxt = ~cur;
            HEAD_SET:    nxt = 1'b1;
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/jksr_head.sv
module jksr_head
    import jksr_pkg::*;
(
    input  logic j,
    input  logic k_n,
    input  logic cur,
    output logic nxt
);
    head_act_e act;

    always_comb begin
        act = decode_head(j, k_n);
        nxt = head_next(act, cur);
    end
endmodule

// File: rtl/jksr_stage.sv
module jksr_stage
    import jksr_pkg::*;
(
    input  logic  clk,
    input  logic  clr_n,
    input  mode_e mode,
    input  logic  par_bit,
    input  logic  shift_bit,
    output logic  q
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else if (mode == MODE_LOAD) begin
            q <= par_bit;
        end else begin
            q <= shift_bit;
        end
    end
endmodule

// File: rtl/jksr_shift_reg.sv
module jksr_shift_reg
    import jksr_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift_ld,
    input  logic              j,
    input  logic              k_n,
    input  logic [STAGES-1:0] par_d,
    output logic [STAGES-1:0] q,
    output logic              q_last_n
);
    localparam int LAST = STAGES - 1;

    mode_e             mode;
    logic              head_d;
    logic [STAGES-1:0] shift_in;

    assign mode = mode_e'(shift_ld);

    jksr_head u_head (
        .j   (j),
        .k_n (k_n),
        .cur (q[0]),
        .nxt (head_d)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign shift_in[i] = head_d;
        end else begin : g_rest
            assign shift_in[i] = q[i-1];
        end

        jksr_stage u_stage (
            .clk       (clk),
            .clr_n     (clr_n),
            .mode      (mode),
            .par_bit   (par_d[i]),
            .shift_bit (shift_in[i]),
            .q         (q[i])
        );
    end

    assign q_last_n = ~q[LAST];
endmodule

// File: rtl/jksr_shift_reg_chk.sv
module jksr_shift_reg_chk #(
    parameter int STAGES = 4
) (
    input logic              clk,
    input logic              clr_n,
    input logic              shift_ld,
    input logic              j,
    input logic              k_n,
    input logic [STAGES-1:0] par_d,
    input logic [STAGES-1:0] q
);
    // Set once an edge has passed with clear released; dropped by any clear.
    logic run_ok;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) run_ok <= 1'b0;
        else        run_ok <= 1'b1;
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        run_ok && !$past(shift_ld) |-> q == $past(par_d)); // R1

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
        run_ok && $past(shift_ld) |-> q[STAGES-1:1] == $past(q[STAGES-2:0])); // R3

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        run_ok && $past(shift_ld) && !$past(j) && $past(k_n) |-> q[0] == $past(q[0])); // R4

    AST_HEAD_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
        run_ok && $past(shift_ld) && !$past(j) && !$past(k_n) |-> q[0] == 1'b0); // R5

    AST_HEAD_SET: assert property (@(posedge clk) disable iff (!clr_n)
        run_ok && $past(shift_ld) && $past(j) && $past(k_n) |-> q[0] == 1'b1); // R6

    AST_HEAD_TOGGLE: assert property (@(posedge clk) disable iff (!clr_n)
        run_ok && $past(shift_ld) && $past(j) && !$past(k_n) |-> q[0] != $past(q[0])); // R7

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (clr_n)
        q == '0); // R8
endmodule

bind jksr_shift_reg jksr_shift_reg_chk #(.STAGES(STAGES)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_ld (shift_ld),
    .j        (j),
    .k_n      (k_n),
    .par_d    (par_d),
    .q        (q)
);

// File: tb/jksr_shift_reg_bench.sv
module jksr_shift_reg_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         shift_ld = 1'b0;
    logic         j = 1'b0;
    logic         k_n = 1'b1;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [W-1:0] q;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] model = '0;

    always #10 clk = ~clk;   // 50 MHz

    jksr_shift_reg #(.STAGES(W)) u_jksr_shift_reg (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_ld (shift_ld),
        .j        (j),
        .k_n      (k_n),
        .par_d    (par_d),
        .q        (q),
        .q_last_n (q_last_n)
    );

    task automatic check(input string req, input logic [W-1:0] exp_q);
        n_checks++;
        if (q !== exp_q || q_last_n !== ~exp_q[W-1]) begin
            n_fail++;
            $display("FAIL %s: q=%b q_last_n=%b expected q=%b q_last_n=%b",
                     req, q, q_last_n, exp_q, ~exp_q[W-1]);
        end
    endtask

    function automatic logic [W-1:0] predict(input logic [W-1:0] cur, input logic sl,
                                             input logic jj, input logic kk,
                                             input logic [W-1:0] d);
        logic hd;
        if (!sl) return d;
        case ({jj, kk})
            2'b00:   hd = 1'b0;
            2'b01:   hd = cur[0];
            2'b10:   hd = ~cur[0];
            default: hd = 1'b1;
        endcase
        return {cur[W-2:0], hd};
    endfunction

    // Driver: one rising edge, one scoreboard entry.
    task automatic cycle(input logic sl, input logic jj, input logic kk,
                         input logic [W-1:0] d, input string tag);
        @(negedge clk);
        shift_ld = sl; j = jj; k_n = kk; par_d = d;
        model = predict(model, sl, jj, kk, d);
        sb.push_back('{model, tag});
        @(posedge clk);
    endtask

    // Clear falls mid-period; either released before the next edge or held over it.
    task automatic clear_mid(input bit hold, input logic sl, input logic jj,
                             input logic kk, input logic [W-1:0] d);
        @(negedge clk);
        shift_ld = sl; j = jj; k_n = kk; par_d = d;
        #3 clr_n = 1'b0;
        #1 check("R8 async clear", '0);
        model = '0;
        if (!hold) begin
            #2 clr_n = 1'b1;
            model = predict(model, sl, jj, kk, d);
            sb.push_back('{model, "R11 first edge after clear"});
        end else begin
            sb.push_back('{model, "R8 clear held over edge"});
        end
        @(posedge clk);
        if (hold) #3 clr_n = 1'b1;
    endtask

    // R10: inputs wiggle between edges, outputs must not move.
    task automatic idle_wiggle();
        @(posedge clk);
        #3 shift_ld = ~shift_ld; j = ~j; k_n = ~k_n; par_d = ~par_d;
        #3 par_d = par_d ^ 4'b0110; shift_ld = ~shift_ld;
        #2 check("R10 hold between edges", model);
        sb.push_back('{model, "R10 hold at edge"});
        shift_ld = 1'b1; j = 1'b0; k_n = 1'b1;
        model = predict(model, 1'b1, 1'b0, 1'b1, par_d);
        sb.pop_back();
        sb.push_back('{model, "R4 hold after idle"});
    endtask

    // Monitor: compare after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, e.q);
            end
        end
    end

    initial begin
        #1 clr_n = 1'b0;
        #5 check("R8 reset state", '0);
        @(negedge clk);
        clr_n = 1'b1;

        cycle(1'b0, 1'b1, 1'b0, 4'b1010, "R1 R2 load");
        cycle(1'b0, 1'b0, 1'b0, 4'b0101, "R1 R2 load");
        cycle(1'b1, 1'b0, 1'b1, 4'b1111, "R3 R4 shift hold");
        cycle(1'b1, 1'b1, 1'b1, 4'b0000, "R3 R6 shift set");
        cycle(1'b1, 1'b0, 1'b0, 4'b1111, "R3 R5 shift clear");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R3 R7 toggle");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R3 R7 toggle");
        cycle(1'b1, 1'b1, 1'b0, 4'b0000, "R7 R9 toggle");
        cycle(1'b0, 1'b1, 1'b1, 4'b1000, "R1 R9 load msb");
        idle_wiggle();
        @(posedge clk);
        clear_mid(1'b0, 1'b0, 1'b1, 1'b0, 4'b1100);
        clear_mid(1'b1, 1'b1, 1'b1, 1'b1, 4'b1111);
        cycle(1'b1, 1'b1, 1'b1, 4'b0000, "R11 shift after held clear");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[4:0] == 5'd7)
                clear_mid(r[5], r[6], r[7], r[8], r[12:9]);
            else
                cycle(r[6], r[7], r[8], r[12:9], "R3 R7 random");
        end
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule